// File: doc/BRIEF.md
# Page Programming Buffer and Timer

This block sits behind the serial command decoder of a byte-wide nonvolatile memory. For a write command it collects the incoming data bytes into a page-sized holding buffer. It then commits the whole page to the storage array through a synchronous write port, inside a self-timed programming window. The decoder tells it three things: when a write command begins, together with its start address; when each data byte has been received; and when chip select rises. On that rise the decoder also reports whether the rise fell in the clock-low gap right after the final data bit, and whether the write is permitted by the enable latch and by block protection.

During the programming window the block writes the buffer to the array, one byte per clock in index order. It holds a busy flag for the full programmed duration so that the status logic can report it. When the window ends it emits a one-cycle pulse that clears the write-enable latch. Any write that is misaligned, not permitted or carries no data is dropped without a busy period.

Top module: `page_prog_engine`

## Requirements
- R1: After reset, `busy`, `mem_we` and `wel_clr` are all low.
- R2: Each received byte is stored at the in-page index taken from the low 7 bits of `start_addr`, which advances by one per byte and wraps from 127 to 0. The upper address bits never change during a command. Each array write goes to address {upper bits of `start_addr`, index}.
- R3: When more than 128 bytes are received, a later byte overwrites the earlier byte at the same wrapped index, and only the last value is committed.
- R4: A `cs_rise` with `cs_rise_clean` low aborts the command: no busy period, no array write, no `wel_clr`.
- R5: A `cs_rise` with `prot_ok` low aborts the command with the same effect as R4.
- R6: A `cs_rise` after a command that received no data byte aborts the command with the same effect as R4.
- R7: An accepted commit raises `busy` in the cycle after `cs_rise`. From that cycle, `mem_we` is high for exactly 128 consecutive cycles, writing indices 0,1,...,127 in order, and only while `busy` is high.
- R8: `busy` stays high for exactly PROG_CYCLES consecutive cycles per accepted commit.
- R9: `wel_clr` is high for exactly one cycle: the first cycle after `busy` falls. It is never high at any other time.
- R10: While `busy` is high, `wr_begin`, `byte_vld` and `cs_rise` have no effect. The committed data and the busy length are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_begin | input | 1 | Pulse: a write command starts, `start_addr` valid |
| start_addr | input | AW | Start address of the write command |
| byte_vld | input | 1 | Pulse: one data byte received |
| byte_data | input | 8 | Received data byte |
| cs_rise | input | 1 | Pulse: chip select rose |
| cs_rise_clean | input | 1 | The rise fell right after the last data bit |
| prot_ok | input | 1 | Write enable set and page not protected |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | AW | Array write address |
| mem_wdata | output | 8 | Array write data |
| busy | output | 1 | Programming window active |
| wel_clr | output | 1 | One-cycle pulse to clear the write-enable latch |

## Verification
The bench covers several cases:
- a start address in mid-page, where a design that carried the index into the upper address bits would write outside the page;
- a 200-byte burst, where a design without wrap would miss the overwrite or commit stale bytes;
- a partial page that crosses index 127, which catches an index that saturates.

Aborted commits are driven with an unclean rise, with protection refused and with no data. A design that ignored any gate would show a busy period or writes. Command traffic injected during programming exposes a design that keeps accepting input, because it would corrupt later array writes or stretch the busy window.

// File: rtl/page_prog_engine.sv
module page_prog_engine #(
  parameter int AW          = 17,
  parameter int PAGE_BITS   = 7,
  parameter int PROG_CYCLES = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_begin,
  input  logic [AW-1:0] start_addr,
  input  logic          byte_vld,
  input  logic [7:0]    byte_data,
  input  logic          cs_rise,
  input  logic          cs_rise_clean,
  input  logic          prot_ok,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          busy,
  output logic          wel_clr
);
  localparam int PAGE = 1 << PAGE_BITS;
  localparam int TW   = $clog2(PROG_CYCLES);

  logic [7:0]             pbuf [PAGE];
  logic [AW-1:PAGE_BITS]  page_q;
  logic [PAGE_BITS-1:0]   idx_q;
  logic [PAGE_BITS:0]     wptr;
  logic [TW-1:0]          tmr;
  logic                   collecting, got, busy_q, clr_q;
  logic                   take, commit;

  assign take   = collecting && !busy_q && !wr_begin && byte_vld;
  assign commit = collecting && !busy_q && !wr_begin && cs_rise
                  && cs_rise_clean && prot_ok && got;

  assign mem_we    = busy_q && !wptr[PAGE_BITS];
  assign mem_addr  = {page_q, wptr[PAGE_BITS-1:0]};
  assign mem_wdata = pbuf[wptr[PAGE_BITS-1:0]];
  assign busy      = busy_q;
  assign wel_clr   = clr_q;

  always_ff @(posedge clk)
    if (take) pbuf[idx_q] <= byte_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q     <= '0;
      idx_q      <= '0;
      wptr       <= '0;
      tmr        <= '0;
      collecting <= 1'b0;
      got        <= 1'b0;
      busy_q     <= 1'b0;
      clr_q      <= 1'b0;
    end else begin
      clr_q <= 1'b0;
      if (busy_q) begin
        if (!wptr[PAGE_BITS]) wptr <= wptr + 1'b1;
        if (tmr == TW'(PROG_CYCLES - 1)) begin
          busy_q <= 1'b0;
          clr_q  <= 1'b1;
        end else begin
          tmr <= tmr + 1'b1;
        end
      end else if (wr_begin) begin
        page_q     <= start_addr[AW-1:PAGE_BITS];
        idx_q      <= start_addr[PAGE_BITS-1:0];
        collecting <= 1'b1;
        got        <= 1'b0;
      end else begin
        if (take) begin
          idx_q <= idx_q + 1'b1;
          got   <= 1'b1;
        end
        if (collecting && cs_rise) begin
          collecting <= 1'b0;
          if (commit) begin
            busy_q <= 1'b1;
            tmr    <= '0;
            wptr   <= '0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/page_prog_engine_chk.sv
module page_prog_engine_chk #(
  parameter int AW          = 17,
  parameter int PAGE_BITS   = 7,
  parameter int PROG_CYCLES = 1000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_rise,
  input logic          cs_rise_clean,
  input logic          prot_ok,
  input logic          busy,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          wel_clr
);
  int unsigned bcnt;

  always_ff @(posedge clk)
    if (!rst_n) bcnt <= 0;
    else        bcnt <= busy ? bcnt + 1 : 0;

  p_we_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
  p_first_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (mem_we && mem_addr[PAGE_BITS-1:0] == '0));
  p_page_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |->
      (mem_addr[AW-1:PAGE_BITS] == $past(mem_addr[AW-1:PAGE_BITS]) &&
       mem_addr[PAGE_BITS-1:0] == $past(mem_addr[PAGE_BITS-1:0]) + 1'b1));
  p_unclean_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cs_rise && !cs_rise_clean) |=> !busy);
  p_prot_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cs_rise && !prot_ok) |=> !busy);
  p_busy_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (bcnt == PROG_CYCLES));
  p_clr_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |-> (!busy && $past(busy)));
  p_clr_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |=> !wel_clr);
endmodule

bind page_prog_engine page_prog_engine_chk #(
  .AW(AW), .PAGE_BITS(PAGE_BITS), .PROG_CYCLES(PROG_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .cs_rise_clean(cs_rise_clean),
  .prot_ok(prot_ok), .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr),
  .wel_clr(wel_clr)
);

// File: tb/page_prog_engine_bench.sv
module page_prog_engine_bench;
  localparam int AW   = 17;
  localparam int PROG = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_begin = 1'b0, byte_vld = 1'b0, cs_rise = 1'b0;
  logic cs_rise_clean = 1'b0, prot_ok = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [7:0] byte_data = '0;
  logic mem_we, busy, wel_clr;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata;

  always #2 clk = ~clk;

  page_prog_engine #(.AW(AW), .PAGE_BITS(7), .PROG_CYCLES(PROG)) u_page_prog_engine (
    .clk(clk), .rst_n(rst_n), .wr_begin(wr_begin), .start_addr(start_addr),
    .byte_vld(byte_vld), .byte_data(byte_data), .cs_rise(cs_rise),
    .cs_rise_clean(cs_rise_clean), .prot_ok(prot_ok), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy), .wel_clr(wel_clr)
  );

  int exp_a[$];
  int exp_d[$];
  int exp_page = 0;
  int mon_run = 0, mon_fail = 0, drv_run = 0, drv_fail = 0, wd_fail = 0;
  int wr_cnt = 0, busy_cnt = 0, clr_cnt = 0, seq = 0;
  logic prev_busy = 1'b0;

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed",
             mon_run + drv_run + wd_fail, mon_fail + drv_fail + wd_fail);
    $finish;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    drv_run++;
    if (act != exp) begin
      drv_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (mem_we) begin
      wr_cnt++;
      mon_run++;
      if (int'(mem_addr[AW-1:7]) != exp_page || int'(mem_addr[6:0]) != seq) begin
        mon_fail++;
        $display("FAIL R2/R7 addr: actual %h expected %h", mem_addr, (exp_page << 7) | seq);
      end
      seq = (seq + 1) % 128;
      if (exp_a.size() > 0 && exp_a[0] == int'(mem_addr)) begin
        mon_run++;
        if (int'(mem_wdata) != exp_d[0]) begin
          mon_fail++;
          $display("FAIL R2/R3/R10 data @%h: actual %h expected %h", mem_addr, mem_wdata, exp_d[0]);
        end
        void'(exp_a.pop_front());
        void'(exp_d.pop_front());
      end
    end
    if (busy) busy_cnt++;
    if (wel_clr) clr_cnt++;
    if (prev_busy && !busy) begin
      mon_run++;
      if (!wel_clr) begin
        mon_fail++;
        $display("FAIL R9 wel_clr after busy: actual 0 expected 1");
      end
    end else if (wel_clr) begin
      mon_run++;
      mon_fail++;
      $display("FAIL R9 stray wel_clr: actual 1 expected 0");
    end
    prev_busy = busy;
  end

  task automatic run_cmd(input int saddr, input int nbytes, input int seed,
                         input logic clean, input logic prot, input bit expect_commit,
                         input bit disturb, input string req);
    int mdl[128];
    bit vld[128];
    int w0, b0, c0;
    for (int i = 0; i < 128; i++) vld[i] = 1'b0;
    @(negedge clk);
    wr_begin = 1'b1; start_addr = AW'(saddr);
    @(negedge clk);
    wr_begin = 1'b0;
    for (int i = 0; i < nbytes; i++) begin
      int ix = ((saddr & 127) + i) % 128;
      int d = (seed * 37 + i * 13 + (i >> 7)) & 255;
      byte_vld = 1'b1; byte_data = 8'(d);
      mdl[ix] = d; vld[ix] = 1'b1;
      @(negedge clk);
      byte_vld = 1'b0;
      @(negedge clk);
    end
    exp_page = saddr >> 7;
    seq = 0;
    if (expect_commit)
      for (int i = 0; i < 128; i++)
        if (vld[i]) begin
          exp_a.push_back(((saddr >> 7) << 7) | i);
          exp_d.push_back(mdl[i]);
        end
    w0 = wr_cnt; b0 = busy_cnt; c0 = clr_cnt;
    cs_rise = 1'b1; cs_rise_clean = clean; prot_ok = prot;
    @(negedge clk);
    cs_rise = 1'b0;
    chk({req, " busy after cs_rise"}, int'(busy), int'(expect_commit));
    if (disturb) begin
      @(negedge clk);
      wr_begin = 1'b1; start_addr = 17'h00050;
      @(negedge clk);
      wr_begin = 1'b0;
      for (int i = 0; i < 5; i++) begin
        byte_vld = 1'b1; byte_data = 8'hEE;
        @(negedge clk);
        byte_vld = 1'b0;
      end
      cs_rise = 1'b1; cs_rise_clean = 1'b1; prot_ok = 1'b1;
      @(negedge clk);
      cs_rise = 1'b0;
    end
    repeat (PROG + 10) @(negedge clk);
    chk({req, " write count"}, wr_cnt - w0, expect_commit ? 128 : 0);
    chk({req, " busy cycles (R8)"}, busy_cnt - b0, expect_commit ? PROG : 0);
    chk({req, " wel_clr pulses (R9)"}, clr_cnt - c0, expect_commit ? 1 : 0);
    chk({req, " pending expected bytes"}, exp_a.size(), 0);
    exp_a.delete(); exp_d.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    wd_fail = 1;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    @(negedge clk);
    chk("R1 busy at reset", int'(busy), 0);
    chk("R1 mem_we at reset", int'(mem_we), 0);
    chk("R1 wel_clr at reset", int'(wel_clr), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    run_cmd(17'h12300, 128, 1, 1'b1, 1'b1, 1'b1, 1'b0, "R7 full aligned page");
    run_cmd(17'h04A75, 128, 2, 1'b1, 1'b1, 1'b1, 1'b0, "R2 mid-page start");
    run_cmd(17'h1FF80, 200, 3, 1'b1, 1'b1, 1'b1, 1'b0, "R3 overlong burst");
    run_cmd(17'h0A37C, 10, 4, 1'b1, 1'b1, 1'b1, 1'b0, "R2 partial wrap");
    run_cmd(17'h00400, 128, 5, 1'b0, 1'b1, 1'b0, 1'b0, "R4 unclean rise");
    run_cmd(17'h00400, 128, 6, 1'b1, 1'b0, 1'b0, 1'b0, "R5 protected");
    run_cmd(17'h00400, 0, 7, 1'b1, 1'b1, 1'b0, 1'b0, "R6 no data");
    run_cmd(17'h15500, 128, 8, 1'b1, 1'b1, 1'b1, 1'b1, "R10 traffic while busy");
    run_cmd(17'h00081, 128, 9, 1'b1, 1'b1, 1'b1, 1'b0, "R7 after aborts");
    summary();
  end
endmodule